// File: doc/BRIEF.md
# Change-Triggered Key Matrix Scanner

This block watches a 3-row by 4-column key matrix. Column inputs are active low and held high by pull-ups. Row outputs work like open-drain drivers: a row that is pulled drives the line low, and a row that is released floats.

While the scanner is idle it pulls all rows low, so a key press anywhere pulls its column low. When the column pattern differs from the pattern seen at the last scan start, the scanner begins a scan. In each scan cycle it pulls rows 1, 2 and 3 low one at a time, one slot each, and then leaves a fourth slot with no row pulled. At the end of every slot that has a row pulled, it samples the columns. A 12-bit key image is committed only when two complete scan cycles in a row read the same matrix. The commit also raises a change flag for the serial side to report.

Scanning continues until the host resynchronises the link with a double chip-select pulse and then sends a display frame. The chip-select falling edge that closes that frame stops the scan. The serial protocol itself is not part of this block. It is seen only through the chip-select level, a resync pulse and a key-frame-read pulse.

Top module: `key_scan_ctl`

## Requirements
- R1: After reset all rows are pulled, the key image is zero, the change flag is low and no scan is active.
- R2: The key at row r, column c (both counted from 1) is image bit (r-1)*4 + (c-1), counted from 0. A pressed key reads 1. S11 is therefore bit 0 and S34 is bit 11.
- R3: While no scan is active, `row_pull_o` is 3'b111, meaning all rows are pulled low.
- R4: While idle, a synchronised column value that differs from the value stored at the last scan start begins a scan on the next clock. For SYNC_STAGES+1 cycles after a stop, no scan can begin.
- R5: During a scan, the scan cycle is SCAN_TICKS ticks long and is split into four equal slots. Slots 0, 1 and 2 pull only row 1, row 2 and row 3 in turn. Slot 3 pulls no row.
- R6: A resync pulse arms the stop. The next chip-select falling edge after arming stops the scan and disarms the stop. A falling edge in the same cycle as the resync pulse does not stop the scan. A falling edge that arrives while the stop is not armed has no effect.
- R7: The image changes only at the end of a scan cycle. The 12-bit read of that cycle must equal the read of the previous complete cycle of the same scan run, and must differ from the current image.
- R8: Every image update sets `key_event_o` on the same clock edge.
- R9: A `key_read_i` pulse clears `key_event_o`. If an update happens in the same cycle as the pulse, the flag stays set.
- R10: The slot counter advances only on cycles where `tick_i` is high. Between ticks, the row outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One bit-time tick, which advances the scan counter |
| col_n_i | input | 4 | Column lines, low when a key on a pulled row is pressed |
| cs_i | input | 1 | Host chip-select level |
| resync_i | input | 1 | Pulse: the serial side has seen a double chip-select pulse |
| key_read_i | input | 1 | Pulse: the keyscan frame has been read out |
| row_pull_o | output | 3 | 1 means the row is driven low, 0 means the row is released |
| key_image_o | output | 12 | Debounced key image, using the bit map of R2 |
| key_event_o | output | 1 | Change flag for the host |
| scan_active_o | output | 1 | A scan is in progress |

## Verification
Two things can land on the same clock edge: a debounced image commit, which sets the change flag, and the host's key-frame read, which clears it. The behavioural model in the bench predicts, before each edge, whether a commit will happen on that edge. During one phase of the test, the bench issues the read pulse on exactly those edges. The flag must then stay high and the image must take the new value, and the model checks this on every cycle. Separately, a resync pulse is sent together with a chip-select fall, to show that this fall does not stop the scan.

// File: rtl/kms_pkg.sv
package kms_pkg;

  typedef enum logic [1:0] {
    KS_IDLE   = 2'd0,
    KS_SCAN   = 2'd1,
    KS_SETTLE = 2'd2
  } ks_state_e;

  // slot number for a counter value
  function automatic int unsigned slot_of(input int unsigned cnt, input int unsigned slot_len);
    return cnt / slot_len;
  endfunction

  // true on the last tick of a slot
  function automatic logic slot_last(input int unsigned cnt, input int unsigned slot_len);
    return (cnt % slot_len) == (slot_len - 1);
  endfunction

endpackage

// File: rtl/kms_col_sync.sv
module kms_col_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= '1;
        else        stg[0] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[g] <= '1;
        else        stg[g] <= stg[g-1];
      end
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/kms_row_timer.sv
module kms_row_timer #(
  parameter int ROWS       = 3,
  parameter int SCAN_TICKS = 260,
  localparam int RW        = $clog2(ROWS + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            tick,
  output logic [ROWS-1:0] row_pull,
  output logic [RW-1:0]   row_idx,
  output logic            sample_evt,
  output logic            cycle_end
);
  localparam int SLOT = SCAN_TICKS / (ROWS + 1);
  localparam int CW   = $clog2(SCAN_TICKS);

  logic [CW-1:0] cnt;
  int unsigned   slot_raw;
  logic          at_slot_end;
  logic          row_slot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (!run) cnt <= '0;
    else if (tick) cnt <= (cnt == CW'(SCAN_TICKS - 1)) ? '0 : cnt + 1'b1;
  end

  always_comb begin
    slot_raw    = kms_pkg::slot_of(32'(cnt), SLOT);
    row_idx     = (slot_raw > ROWS) ? RW'(ROWS) : RW'(slot_raw);
    at_slot_end = kms_pkg::slot_last(32'(cnt), SLOT);
  end

  assign row_slot = (row_idx < RW'(ROWS));

  for (genvar g = 0; g < ROWS; g++) begin : g_row
    assign row_pull[g] = !run || (row_idx == RW'(g));
  end

  assign sample_evt = run && tick && row_slot && at_slot_end;
  assign cycle_end  = sample_evt && (row_idx == RW'(ROWS - 1));
endmodule

// File: rtl/kms_debounce.sv
module kms_debounce #(
  parameter int ROWS  = 3,
  parameter int COLS  = 4,
  localparam int KEYS = ROWS * COLS,
  localparam int RW   = $clog2(ROWS + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_evt,
  input  logic            sample_evt,
  input  logic            cycle_end,
  input  logic [RW-1:0]   row_idx,
  input  logic [COLS-1:0] col_s,
  input  logic            key_read,
  output logic [KEYS-1:0] image,
  output logic            event_flag,
  output logic            capture_evt
);
  logic [KEYS-1:0] raw_q, prev_q, full;
  logic            prev_ok;

  always_comb begin
    full = raw_q;
    for (int r = 0; r < ROWS; r++) begin
      if (row_idx == RW'(r)) full[r*COLS +: COLS] = ~col_s;
    end
  end

  assign capture_evt = cycle_end && prev_ok && (full == prev_q) && (full != image);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q      <= '0;
      prev_q     <= '0;
      prev_ok    <= 1'b0;
      image      <= '0;
      event_flag <= 1'b0;
    end else begin
      if (sample_evt) raw_q <= full;
      if (start_evt) begin
        prev_ok <= 1'b0;
      end else if (cycle_end) begin
        prev_q  <= full;
        prev_ok <= 1'b1;
      end
      if (capture_evt) image <= full;
      if (capture_evt)   event_flag <= 1'b1;
      else if (key_read) event_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/kms_seq.sv
module kms_seq #(
  parameter int W      = 4,
  parameter int SETTLE = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs_i,
  input  logic         resync_i,
  input  logic [W-1:0] col_s,
  output logic         scanning,
  output logic         start_evt,
  output logic         stop_evt
);
  import kms_pkg::*;
  localparam int SW = $clog2(SETTLE + 1);

  ks_state_e     state;
  logic [SW-1:0] settle_cnt;
  logic [W-1:0]  ref_q;
  logic          cs_q, armed_q, cs_fall;

  assign cs_fall   = cs_q && !cs_i;
  assign stop_evt  = (state == KS_SCAN) && armed_q && cs_fall;
  assign start_evt = (state == KS_IDLE) && (col_s != ref_q);
  assign scanning  = (state == KS_SCAN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= KS_IDLE;
      settle_cnt <= '0;
      ref_q      <= '1;
      cs_q       <= 1'b0;
      armed_q    <= 1'b0;
    end else begin
      cs_q <= cs_i;
      if (resync_i)     armed_q <= 1'b1;
      else if (cs_fall) armed_q <= 1'b0;
      if (start_evt) ref_q <= col_s;
      case (state)
        KS_IDLE:   if (start_evt) state <= KS_SCAN;
        KS_SCAN:   if (stop_evt) begin
                     state      <= KS_SETTLE;
                     settle_cnt <= SW'(SETTLE - 1);
                   end
        KS_SETTLE: if (settle_cnt == '0) state <= KS_IDLE;
                   else                  settle_cnt <= settle_cnt - 1'b1;
        default:   state <= KS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/key_scan_ctl.sv
module key_scan_ctl #(
  parameter int ROWS        = 3,
  parameter int COLS        = 4,
  parameter int SCAN_TICKS  = 260,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_i,
  input  logic [COLS-1:0]      col_n_i,
  input  logic                 cs_i,
  input  logic                 resync_i,
  input  logic                 key_read_i,
  output logic [ROWS-1:0]      row_pull_o,
  output logic [ROWS*COLS-1:0] key_image_o,
  output logic                 key_event_o,
  output logic                 scan_active_o
);
  localparam int RW     = $clog2(ROWS + 1);
  localparam int SETTLE = SYNC_STAGES + 1;

  // named internal events, observed by the checker
  logic [COLS-1:0] col_s;
  logic            start_evt, stop_evt, sample_evt, cycle_end, capture_evt;
  logic [RW-1:0]   row_idx;

  kms_col_sync #(.W(COLS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(col_n_i), .dout(col_s)
  );

  kms_seq #(.W(COLS), .SETTLE(SETTLE)) u_seq (
    .clk(clk), .rst_n(rst_n), .cs_i(cs_i), .resync_i(resync_i), .col_s(col_s),
    .scanning(scan_active_o), .start_evt(start_evt), .stop_evt(stop_evt)
  );

  kms_row_timer #(.ROWS(ROWS), .SCAN_TICKS(SCAN_TICKS)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(scan_active_o), .tick(tick_i),
    .row_pull(row_pull_o), .row_idx(row_idx),
    .sample_evt(sample_evt), .cycle_end(cycle_end)
  );

  kms_debounce #(.ROWS(ROWS), .COLS(COLS)) u_deb (
    .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .sample_evt(sample_evt),
    .cycle_end(cycle_end), .row_idx(row_idx), .col_s(col_s), .key_read(key_read_i),
    .image(key_image_o), .event_flag(key_event_o), .capture_evt(capture_evt)
  );
endmodule

// File: rtl/key_scan_ctl_checker.sv
module key_scan_ctl_checker #(
  parameter int ROWS = 3,
  parameter int COLS = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 tick_i,
  input logic                 key_read_i,
  input logic [ROWS-1:0]      row_pull_o,
  input logic [ROWS*COLS-1:0] key_image_o,
  input logic                 key_event_o,
  input logic                 scan_active_o,
  input logic                 start_evt,
  input logic                 stop_evt,
  input logic                 sample_evt,
  input logic                 capture_evt
);
  a_r3_rows_low_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scan_active_o) |-> (&row_pull_o));
  a_r5_one_row_in_scan: assert property (@(posedge clk) disable iff (!rst_n)
    scan_active_o |-> $onehot0(row_pull_o));
  a_r4_start_enters_scan: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> scan_active_o);
  a_r6_stop_leaves_scan: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !scan_active_o);
  a_r7_image_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !capture_evt |=> $stable(key_image_o));
  a_r7_commit_at_sample: assert property (@(posedge clk) disable iff (!rst_n)
    capture_evt |-> sample_evt);
  a_r8_flag_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
    capture_evt |=> key_event_o);
  a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (key_read_i && !capture_evt) |=> !key_event_o);
  a_r10_rows_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_active_o && !tick_i) |=> ($stable(row_pull_o) || !scan_active_o));
endmodule

bind key_scan_ctl key_scan_ctl_checker #(.ROWS(ROWS), .COLS(COLS)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .key_read_i(key_read_i),
  .row_pull_o(row_pull_o), .key_image_o(key_image_o), .key_event_o(key_event_o),
  .scan_active_o(scan_active_o), .start_evt(start_evt), .stop_evt(stop_evt),
  .sample_evt(sample_evt), .capture_evt(capture_evt)
);

// File: tb/key_scan_ctl_bench.sv
`timescale 1ns/1ps
module key_scan_ctl_bench;
  localparam int COLS = 4, KEYS = 12, ST = 16, SLOT = 4, SETTLE = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  // caller-side intent, applied at the next negedge
  logic g_tick = 1'b1, g_cs = 1'b0, g_res = 1'b0, g_rd = 1'b0;
  logic [KEYS-1:0] g_keys = '0;
  // driven DUT inputs
  logic d_tick = 1'b1, d_cs = 1'b0, d_res = 1'b0, d_rd = 1'b0;
  logic [KEYS-1:0] d_keys = '0;

  logic [COLS-1:0] col_n;
  logic [2:0]      row_pull;
  logic [KEYS-1:0] image;
  logic            evt, scan;

  function automatic logic [COLS-1:0] matrix(input logic [KEYS-1:0] k, input logic [2:0] rp);
    logic [COLS-1:0] v;
    for (int c = 0; c < COLS; c++) begin
      v[c] = 1'b1;
      for (int r = 0; r < 3; r++) if (rp[r] && k[r*COLS+c]) v[c] = 1'b0;
    end
    return v;
  endfunction

  assign col_n = matrix(d_keys, row_pull);

  key_scan_ctl #(.SCAN_TICKS(ST)) u_key_scan_ctl (
    .clk(clk), .rst_n(rst_n), .tick_i(d_tick), .col_n_i(col_n), .cs_i(d_cs),
    .resync_i(d_res), .key_read_i(d_rd), .row_pull_o(row_pull),
    .key_image_o(image), .key_event_o(evt), .scan_active_o(scan)
  );

  // behavioural reference model
  bit              m_scan, m_armed, m_csq, m_prev_ok, m_flag;
  int              m_cnt, m_settle;
  logic [3:0]      m_ref;
  logic [3:0]      sq[$];
  logic [KEYS-1:0] m_raw, m_prev, m_img;

  int checks = 0, errors = 0, cyc_n = 0;
  bit collide_mode = 0;

  task automatic summary_and_end();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] m_rows();
    if (!m_scan) return 3'b111;
    if (m_cnt / SLOT < 3) return 3'(1 << (m_cnt / SLOT));
    return 3'b000;
  endfunction

  function automatic logic [KEYS-1:0] m_full();
    logic [KEYS-1:0] f = m_raw;
    int s = m_cnt / SLOT;
    if (s < 3) f[s*COLS +: COLS] = ~sq[1];
    return f;
  endfunction

  function automatic bit m_sample(input bit ti);
    return m_scan && ti && (m_cnt % SLOT == SLOT - 1) && (m_cnt / SLOT < 3);
  endfunction

  function automatic bit m_commit(input bit ti);
    logic [KEYS-1:0] f = m_full();
    return m_sample(ti) && (m_cnt / SLOT == 2) && m_prev_ok && f == m_prev && f != m_img;
  endfunction

  task automatic m_step(input bit ti, input bit tcs, input bit tres, input bit trd,
                        input logic [KEYS-1:0] k);
    logic [3:0] obs = sq[1];
    logic [KEYS-1:0] f = m_full();
    bit fall = m_csq && !tcs;
    bit stop = m_scan && m_armed && fall;
    bit start = !m_scan && m_settle == 0 && obs != m_ref;
    bit smp = m_sample(ti);
    bit cend = smp && (m_cnt / SLOT == 2);
    bit cap = m_commit(ti);
    logic [3:0] now_col = matrix(k, m_rows());
    sq = '{now_col, sq[0]};
    if (smp) m_raw = f;
    if (cend) begin m_prev = f; m_prev_ok = 1; end
    if (cap) m_img = f;
    m_flag = cap ? 1'b1 : (trd ? 1'b0 : m_flag);
    m_armed = tres ? 1'b1 : (fall ? 1'b0 : m_armed);
    m_csq = tcs;
    if (m_scan && ti) m_cnt = (m_cnt + 1) % ST;
    if (start) begin m_scan = 1; m_cnt = 0; m_ref = obs; m_prev_ok = 0; end
    if (stop) begin m_scan = 0; m_settle = SETTLE; end
    else if (!m_scan && m_settle > 0 && !start) m_settle--;
  endtask

  task automatic compare();
    chk("R5 rows", int'(row_pull), int'(m_rows()));
    chk("R7 image", int'(image), int'(m_img));
    chk("R9 flag", int'(evt), int'(m_flag));
    chk("R4 scan", int'(scan), int'(m_scan));
  endtask

  task automatic cyc(input int n);
    repeat (n) begin
      @(negedge clk);
      compare();
      cyc_n++;
      if (cyc_n > 20000) begin
        errors++;
        $display("FAIL R0 watchdog actual %0d expected below 20000", cyc_n);
        summary_and_end();
      end
      d_tick = g_tick; d_cs = g_cs; d_res = g_res; d_keys = g_keys;
      d_rd = g_rd | (collide_mode & m_commit(g_tick));
      m_step(d_tick, d_cs, d_res, d_rd, d_keys);
    end
  endtask

  task automatic stop_seq();
    g_cs = 1; cyc(2);
    g_cs = 0; cyc(2);
    g_cs = 1; cyc(2);
    g_cs = 0; g_res = 1; cyc(1); g_res = 0;
    g_cs = 1; cyc(4);
    g_cs = 0; cyc(1);
  endtask

  int edges = 0;
  always @(posedge clk) begin
    edges++;
    if (edges > 150000) begin
      errors++;
      $display("FAIL R0 watchdog actual %0d expected below 150000", edges);
      summary_and_end();
    end
  end

  initial begin
    m_scan = 0; m_armed = 0; m_csq = 0; m_prev_ok = 0; m_flag = 0;
    m_cnt = 0; m_settle = 0; m_ref = 4'hF; sq = '{4'hF, 4'hF};
    m_raw = '0; m_prev = '0; m_img = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 rows", int'(row_pull), 7);
    chk("R1 image", int'(image), 0);
    chk("R1 flag", int'(evt), 0);
    chk("R1 scan", int'(scan), 0);

    cyc(10);
    chk("R3 idle rows", int'(row_pull), 7);

    g_keys[0] = 1'b1;          // S11
    cyc(70);
    chk("R2 S11 bit0", int'(image), 12'h001);
    chk("R8 flag set", int'(evt), 1);
    chk("R4 scan began", int'(scan), 1);

    g_rd = 1; cyc(1); g_rd = 0; cyc(1);
    chk("R9 read clears", int'(evt), 0);

    g_cs = 1; cyc(4); g_cs = 0; cyc(4);
    chk("R6 unarmed fall ignored", int'(scan), 1);

    g_cs = 1; cyc(3); g_cs = 0; g_res = 1; cyc(1); g_res = 0; cyc(2);
    chk("R6 fall with resync keeps scan", int'(scan), 1);
    g_cs = 1; cyc(5); g_cs = 0; cyc(1); cyc(1);
    chk("R6 stopped", int'(scan), 0);
    chk("R3 rows after stop", int'(row_pull), 7);
    cyc(10);
    chk("R4 no change no start", int'(scan), 0);

    for (int i = 0; i < 6; i++) begin
      g_keys[5] = ~g_keys[5];  // S22 bounce
      cyc(16);
    end
    chk("R7 bounce ignored", int'(image), 12'h001);

    collide_mode = 1;
    g_keys[5] = 1'b1;
    cyc(60);
    collide_mode = 0;
    chk("R2 S22 bit5", int'(image), 12'h021);
    chk("R9 commit beats read", int'(evt), 1);

    g_keys[0] = 1'b0; g_keys[11] = 1'b1;   // S34
    for (int i = 0; i < 240; i++) begin
      g_tick = (i % 3 == 0);
      cyc(1);
    end
    g_tick = 1;
    chk("R10 slow ticks S34 bit11", int'(image), 12'h820);

    stop_seq();
    g_keys[2] = 1'b1;          // S13, during settle
    cyc(1);
    chk("R4 settle blocks start", int'(scan), 0);
    cyc(8);
    chk("R4 restart after settle", int'(scan), 1);
    cyc(60);
    chk("R2 S13 bit2", int'(image), 12'h824);

    summary_and_end();
  end
endmodule